// File: doc/BRIEF.md
# Half-band decimator with selectable complex, real and zero-padded real output

This block sits behind a digital mixer in a wideband receive path. It takes one complex sample pair per accepted input strobe and reduces the rate by two or by four with fixed half-band low-pass filters. One mode code sets the path for every channel pair at once. The path can give complex output, real output on the in-phase lane only, or real output formed by turning the decimated complex stream a further eighth of its own rate and keeping the real part. In a zero-fill variant of that last path, each real sample is followed by a zero sample, so a full-rate input gives a full-rate output. A bypass code sends the raw samples straight through.

The first stage can act as a high-pass filter in the plain real decimate-by-2 mode only. Both channels of a pair, and all pairs, take the same mode code. The mode must be held constant while data flows, and the block must be reset after the code changes.

Top module: `decim_filter`

## Requirements
- R1: While rst_ni is low, valid_o is 0 and i_o and q_o are 0.
- R2: Mode code 8 (bypass) copies each accepted i_i/q_i pair to i_o/q_o with valid_o high one clock after the input strobe.
- R3: Mode codes 0 and 5 give complex output. Counting accepted samples from 0, each odd-indexed sample n yields, on each lane, y = floor((-x[n] + 9x[n-2] + 16x[n-3] + 9x[n-4] - x[n-6]) / 32). Samples before the first accepted one count as 0. The result appears two clocks after the strobe of sample n.
- R4: Mode code 2 gives the R3 result of the in-phase lane on i_o, with q_o = 0. When hp_sel_i = 1, the 16x[n-3] term is subtracted instead of added (high-pass).
- R5: In every mode other than 2, hp_sel_i has no effect on the output.
- R6: Mode code 6 passes the R3 output streams of both lanes through a second identical low-pass stage. Output comes on every second first-stage result (input samples 3, 7, 11, ...), three clocks after the strobe of the input sample that completes it.
- R7: Mode code 4 takes the k-th complex first-stage result (k counted from 0 after reset) and outputs i_o = floor((I*c_k - Q*s_k) / 32768), with q_o = 0, three clocks after the input strobe. Here c_k and s_k are the cosine and sine of k*45 degrees in Q15: 32767 for one, 23170 for the half-root-two value, 0 for zero, each with its sign.
- R8: Mode code 7 outputs the R7 result and then, on the following clock, a sample with valid_o = 1 and i_o = q_o = 0.
- R9: Any mode code outside {0, 2, 4, 5, 6, 7, 8} keeps valid_o at 0.
- R10: Every filter and rotation result is clamped to the range -32768..32767 before output.
- R11: Clocks with valid_i low are skipped. The sample index n and the output timing count only accepted samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 4 | Path select code, common to all channels |
| hp_sel_i | input | 1 | High-pass select for mode 2 |
| valid_i | input | 1 | Input sample strobe |
| i_i | input | 16 | In-phase input sample, two's complement |
| q_i | input | 16 | Quadrature input sample, two's complement |
| valid_o | output | 1 | Output sample strobe |
| i_o | output | 16 | In-phase or real output sample |
| q_o | output | 16 | Quadrature output sample, 0 in real modes |

## Verification
A wrong decimation phase shifts every output by one input sample, and a wrong tap value or delay-line slot changes the data. Either fault shows on the first output after reset, two or three clocks after the second accepted sample. A wrong rotation step shows on the second real output, because step 0 uses the unit cosine and zero sine. A zero fill that is missing or out of place breaks the strobe pattern within one clock of the first real sample. The bench compares valid_o and both data lanes on every clock against a model built from sample histories, so a fault is seen in the cycle it appears.

// File: rtl/decim_pkg.sv
`timescale 1ns/1ps
package decim_pkg;
  localparam int MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    MODE_CPLX_A  = 4'd0,
    MODE_REAL_D2 = 4'd2,
    MODE_ROT     = 4'd4,
    MODE_CPLX_B  = 4'd5,
    MODE_CPLX_D4 = 4'd6,
    MODE_ROT_PAD = 4'd7,
    MODE_BYPASS  = 4'd8
  } mode_e;
endpackage

// File: rtl/hb_dec2.sv
`timescale 1ns/1ps
module hb_dec2 #(
  parameter int W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic                hp_i,
  input  logic signed [W-1:0] x_i,
  output logic                valid_o,
  output logic signed [W-1:0] y_o
);
  localparam int DEPTH = 6;
  localparam int GROW  = 6;
  localparam int SHIFT = 5;
  localparam int ACC_W = W + GROW;
  localparam logic signed [ACC_W-1:0] MAX_V = ACC_W'((longint'(1) <<< (W-1)) - 1);
  localparam logic signed [ACC_W-1:0] MIN_V = ACC_W'(-(longint'(1) <<< (W-1)));

  logic signed [W-1:0]     dly_q [DEPTH];
  logic                    phase_q;
  logic signed [ACC_W-1:0] e0, e2, e3, e4, e6, mid, acc, shr;
  logic signed [W-1:0]     y_d;

  // window: x_i = x[n], dly_q[k] = x[n-1-k]
  always_comb begin
    e0  = ACC_W'(x_i);
    e2  = ACC_W'(dly_q[1]);
    e3  = ACC_W'(dly_q[2]);
    e4  = ACC_W'(dly_q[3]);
    e6  = ACC_W'(dly_q[5]);
    mid = e3 <<< 4;
    acc = (e2 <<< 3) + e2 + (e4 <<< 3) + e4 - e0 - e6;
    acc = hp_i ? (acc - mid) : (acc + mid);
    shr = acc >>> SHIFT;
    if (shr > MAX_V)      y_d = MAX_V[W-1:0];
    else if (shr < MIN_V) y_d = MIN_V[W-1:0];
    else                  y_d = shr[W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < DEPTH; k++) dly_q[k] <= '0;
      phase_q <= 1'b0;
      valid_o <= 1'b0;
      y_o     <= '0;
    end else begin
      valid_o <= valid_i & phase_q;
      if (valid_i) begin
        dly_q[0] <= x_i;
        for (int k = 1; k < DEPTH; k++) dly_q[k] <= dly_q[k-1];
        phase_q <= ~phase_q;
        if (phase_q) y_o <= y_d;
      end
    end
  end
endmodule

// File: rtl/fs8_rotator.sv
`timescale 1ns/1ps
module fs8_rotator #(
  parameter int W  = 16,
  parameter int CW = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic signed [W-1:0] re_i,
  input  logic signed [W-1:0] im_i,
  output logic                valid_o,
  output logic signed [W-1:0] re_o
);
  localparam int FRAC = CW - 1;
  localparam int PW   = W + CW + 1;
  localparam logic signed [CW-1:0] C_ONE  = CW'((longint'(1) <<< FRAC) - 1);
  localparam logic signed [CW-1:0] C_HALF = CW'(((longint'(1) <<< FRAC) * 23170) >>> 15);
  localparam logic signed [PW-1:0] MAX_V  = PW'((longint'(1) <<< (W-1)) - 1);
  localparam logic signed [PW-1:0] MIN_V  = PW'(-(longint'(1) <<< (W-1)));

  logic [2:0]           step_q;
  logic signed [CW-1:0] c, s;
  logic signed [PW-1:0] prod, shr;
  logic signed [W-1:0]  y_d;

  always_comb begin
    case (step_q)
      3'd0:    begin c = C_ONE;   s = '0;      end
      3'd1:    begin c = C_HALF;  s = C_HALF;  end
      3'd2:    begin c = '0;      s = C_ONE;   end
      3'd3:    begin c = -C_HALF; s = C_HALF;  end
      3'd4:    begin c = -C_ONE;  s = '0;      end
      3'd5:    begin c = -C_HALF; s = -C_HALF; end
      3'd6:    begin c = '0;      s = -C_ONE;  end
      default: begin c = C_HALF;  s = -C_HALF; end
    endcase
    prod = PW'(re_i) * PW'(c) - PW'(im_i) * PW'(s);
    shr  = prod >>> FRAC;
    if (shr > MAX_V)      y_d = MAX_V[W-1:0];
    else if (shr < MIN_V) y_d = MIN_V[W-1:0];
    else                  y_d = shr[W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q  <= '0;
      valid_o <= 1'b0;
      re_o    <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        re_o   <= y_d;
        step_q <= step_q + 3'd1;
      end
    end
  end
endmodule

// File: rtl/decim_filter.sv
`timescale 1ns/1ps
module decim_filter
  import decim_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [MODE_W-1:0]        mode_i,
  input  logic                     hp_sel_i,
  input  logic                     valid_i,
  input  logic signed [DATA_W-1:0] i_i,
  input  logic signed [DATA_W-1:0] q_i,
  output logic                     valid_o,
  output logic signed [DATA_W-1:0] i_o,
  output logic signed [DATA_W-1:0] q_o
);
  localparam int NCH = 2;

  logic signed [DATA_W-1:0] ch_in [NCH];
  logic signed [DATA_W-1:0] s1_y  [NCH];
  logic signed [DATA_W-1:0] s2_y  [NCH];
  logic [NCH-1:0]           s1_v, s2_v;
  logic                     s1_ok, s2_ok, hp_eff, rot_sel, rot_v, pad_q;
  logic signed [DATA_W-1:0] rot_y;

  assign ch_in[0] = i_i;
  assign ch_in[1] = q_i;
  assign hp_eff   = hp_sel_i && (mode_i == MODE_REAL_D2);
  assign rot_sel  = (mode_i == MODE_ROT) || (mode_i == MODE_ROT_PAD);
  assign s1_ok    = &s1_v;
  assign s2_ok    = &s2_v;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    hb_dec2 #(.W(DATA_W)) u_s1 (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .valid_i (valid_i),
      .hp_i    (hp_eff),
      .x_i     (ch_in[c]),
      .valid_o (s1_v[c]),
      .y_o     (s1_y[c])
    );
    hb_dec2 #(.W(DATA_W)) u_s2 (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .valid_i (s1_v[c]),
      .hp_i    (1'b0),
      .x_i     (s1_y[c]),
      .valid_o (s2_v[c]),
      .y_o     (s2_y[c])
    );
  end

  fs8_rotator #(.W(DATA_W), .CW(COEF_W)) u_rot (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (s1_ok && rot_sel),
    .re_i    (s1_y[0]),
    .im_i    (s1_y[1]),
    .valid_o (rot_v),
    .re_o    (rot_y)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      i_o     <= '0;
      q_o     <= '0;
      pad_q   <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      pad_q   <= 1'b0;
      case (mode_e'(mode_i))
        MODE_BYPASS: if (valid_i) begin
          valid_o <= 1'b1; i_o <= i_i; q_o <= q_i;
        end
        MODE_CPLX_A, MODE_CPLX_B: if (s1_ok) begin
          valid_o <= 1'b1; i_o <= s1_y[0]; q_o <= s1_y[1];
        end
        MODE_REAL_D2: if (s1_ok) begin
          valid_o <= 1'b1; i_o <= s1_y[0]; q_o <= '0;
        end
        MODE_CPLX_D4: if (s2_ok) begin
          valid_o <= 1'b1; i_o <= s2_y[0]; q_o <= s2_y[1];
        end
        MODE_ROT: if (rot_v) begin
          valid_o <= 1'b1; i_o <= rot_y; q_o <= '0;
        end
        MODE_ROT_PAD: begin
          if (rot_v) begin
            valid_o <= 1'b1; i_o <= rot_y; q_o <= '0; pad_q <= 1'b1;
          end else if (pad_q) begin
            valid_o <= 1'b1; i_o <= '0; q_o <= '0;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/decim_filter_chk.sv
`timescale 1ns/1ps
module decim_filter_chk
  import decim_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic [MODE_W-1:0]        mode_i,
  input logic                     valid_i,
  input logic signed [DATA_W-1:0] i_i,
  input logic signed [DATA_W-1:0] q_i,
  input logic                     valid_o,
  input logic signed [DATA_W-1:0] i_o,
  input logic signed [DATA_W-1:0] q_o
);
  function automatic logic known_mode(logic [MODE_W-1:0] m);
    return m == MODE_CPLX_A || m == MODE_REAL_D2 || m == MODE_ROT ||
           m == MODE_CPLX_B || m == MODE_CPLX_D4 || m == MODE_ROT_PAD ||
           m == MODE_BYPASS;
  endfunction

  p_bypass_pass_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_BYPASS && valid_i) |=>
      (valid_o && i_o == $past(i_i) && q_o == $past(q_i)));

  p_dec2_spacing_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(mode_i) == MODE_CPLX_A && mode_i == MODE_CPLX_A) |=> !valid_o);

  p_real_q_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && ($past(mode_i) == MODE_REAL_D2 || $past(mode_i) == MODE_ROT ||
                 $past(mode_i) == MODE_ROT_PAD)) |-> (q_o == '0));

  p_dec4_spacing_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(mode_i) == MODE_CPLX_D4 && mode_i == MODE_CPLX_D4) |=> !valid_o);

  p_pad_follows_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && i_o != '0 && $past(mode_i) == MODE_ROT_PAD && mode_i == MODE_ROT_PAD) |=>
      (valid_o && i_o == '0 && q_o == '0));

  p_unknown_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !known_mode($past(mode_i)) |-> !valid_o);
endmodule

bind decim_filter decim_filter_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/decim_filter_tb.sv
`timescale 1ns/1ps
module decim_filter_tb;
  localparam int W       = 16;
  localparam int HORIZON = 1024;

  logic                clk_i = 1'b0;
  logic                rst_ni = 1'b0;
  logic [3:0]          mode_i = '0;
  logic                hp_sel_i = 1'b0;
  logic                valid_i = 1'b0;
  logic signed [W-1:0] i_i = '0;
  logic signed [W-1:0] q_i = '0;
  logic                valid_o;
  logic signed [W-1:0] i_o, q_o;

  int    n_chk = 0, n_err = 0, cyc = 0, rot_k = 0;
  string req = "R1";
  int    ev_v [HORIZON];
  int    ev_i [HORIZON];
  int    ev_q [HORIZON];
  int    hx_i[$], hx_q[$], s1_i[$], s1_q[$];

  always #10 clk_i = ~clk_i;

  decim_filter u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i), .hp_sel_i(hp_sel_i),
    .valid_i(valid_i), .i_i(i_i), .q_i(q_i),
    .valid_o(valid_o), .i_o(i_o), .q_o(q_o)
  );

  function automatic int sat(int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic int tap(int x[$], int k);
    return (k < 0) ? 0 : x[k];
  endfunction

  function automatic int hb(int x[$], int n, bit hp);
    int acc = -tap(x, n) + 9 * tap(x, n-2) + (hp ? -16 : 16) * tap(x, n-3)
              + 9 * tap(x, n-4) - tap(x, n-6);
    return sat(acc >>> 5);
  endfunction

  function automatic int rot(int a, int b, int k);
    int cs[8] = '{32767, 23170, 0, -23170, -32767, -23170, 0, 23170};
    int sn[8] = '{0, 23170, 32767, 23170, 0, -23170, -32767, -23170};
    longint p = longint'(a) * cs[k] - longint'(b) * sn[k];
    return sat(int'(p >>> 15));
  endfunction

  task automatic sched(int idx, int a, int b);
    if (idx < HORIZON) begin
      ev_v[idx] = 1; ev_i[idx] = a; ev_q[idx] = b;
    end
  endtask

  task automatic model(int mode, bit hp, int a, int b);
    int n, m, r;
    hx_i.push_back(a); hx_q.push_back(b);
    n = hx_i.size() - 1;
    case (mode)
      8: sched(cyc + 1, a, b);
      0, 5: if (n % 2 == 1) sched(cyc + 2, hb(hx_i, n, 0), hb(hx_q, n, 0));
      2: if (n % 2 == 1) sched(cyc + 2, hb(hx_i, n, hp), 0);
      6: if (n % 2 == 1) begin
        s1_i.push_back(hb(hx_i, n, 0)); s1_q.push_back(hb(hx_q, n, 0));
        m = s1_i.size() - 1;
        if (m % 2 == 1) sched(cyc + 3, hb(s1_i, m, 0), hb(s1_q, m, 0));
      end
      4, 7: if (n % 2 == 1) begin
        r = rot(hb(hx_i, n, 0), hb(hx_q, n, 0), rot_k);
        rot_k = (rot_k + 1) % 8;
        sched(cyc + 3, r, 0);
        if (mode == 7) sched(cyc + 4, 0, 0);
      end
      default: ;
    endcase
  endtask

  task automatic check_cycle();
    bit ev = (cyc < HORIZON) && (ev_v[cyc] != 0);
    int ei = ev ? ev_i[cyc] : 0;
    int eq = ev ? ev_q[cyc] : 0;
    n_chk++;
    if (valid_o !== ev || (ev && (int'(i_o) != ei || int'(q_o) != eq))) begin
      n_err++;
      $display("FAIL %s cycle %0d: valid=%0b i=%0d q=%0d expected valid=%0b i=%0d q=%0d",
               req, cyc, valid_o, i_o, q_o, ev, ei, eq);
    end
  endtask

  function automatic int pick(int kind, int s, bit lane);
    case (kind)
      0: return int'($urandom_range(65535)) - 32768;
      1: return ((s % 2 == 0) ^ lane) ? 32767 : -32768;
      default: return s * 300 - 12000 + (lane ? 777 : 0);
    endcase
  endfunction

  task automatic do_reset(int mode, bit hp);
    rst_ni = 1'b0; valid_i = 1'b0; mode_i = 4'(mode); hp_sel_i = hp;
    hx_i.delete(); hx_q.delete(); s1_i.delete(); s1_q.delete(); rot_k = 0;
    for (int k = 0; k < HORIZON; k++) ev_v[k] = 0;
    repeat (2) @(negedge clk_i);
    n_chk++;
    if (valid_o !== 1'b0 || i_o !== '0 || q_o !== '0) begin
      n_err++;
      $display("FAIL R1 reset: valid=%0b i=%0d q=%0d expected valid=0 i=0 q=0", valid_o, i_o, q_o);
    end
    rst_ni = 1'b1;
    cyc = 0;
  endtask

  task automatic run(int mode, bit hp, int nsamp, int kind, bit gaps, string tag);
    int s = 0;
    do_reset(mode, hp);
    req = tag;
    while (s < nsamp) begin
      bit v = gaps ? ($urandom_range(2) != 0) : 1'b1;
      valid_i = v;
      if (v) begin
        int a = pick(kind, s, 0);
        int b = pick(kind, s, 1);
        i_i = W'(a); q_i = W'(b);
        model(mode, hp, a, b);
        s++;
      end
      @(posedge clk_i); cyc++;
      @(negedge clk_i); check_cycle();
    end
    valid_i = 1'b0;
    repeat (8) begin
      @(posedge clk_i); cyc++;
      @(negedge clk_i); check_cycle();
    end
  endtask

  initial begin
    run(8, 0, 60, 0, 0, "R2");
    run(8, 0, 40, 0, 1, "R11");
    run(0, 0, 80, 0, 0, "R3");
    run(5, 0, 80, 2, 1, "R11");
    run(5, 0, 60, 0, 0, "R3");
    run(0, 1, 60, 0, 0, "R5");
    run(2, 0, 60, 0, 0, "R4");
    run(2, 1, 60, 0, 0, "R4");
    run(2, 1, 40, 1, 0, "R10");
    run(6, 0, 96, 0, 0, "R6");
    run(6, 1, 80, 2, 1, "R5");
    run(4, 0, 80, 0, 0, "R7");
    run(4, 0, 60, 0, 1, "R7");
    run(4, 1, 40, 1, 0, "R10");
    run(7, 0, 80, 0, 0, "R8");
    run(3, 0, 40, 0, 0, "R9");
    run(15, 0, 40, 0, 0, "R9");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #2000000;
    n_chk++; n_err++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule